// File: doc/BRIEF.md
# Pseudo-SRAM Power State Manager

This block decides when a one-transistor pseudo-SRAM may be used and when it sleeps. After reset it holds the memory in a stabilisation wait of a fixed number of clock cycles. It then raises a ready flag that releases the access sequencer. On a host command it drives the memory's deep-power-down select low. That puts the array into its lowest-current state, and the stored contents are discarded.

A second host command drives the select high again. Another full stabilisation wait follows, and the ready flag returns only when that wait ends. Every such wake-up sets a sticky data-lost flag, which stays set until the host clears it. While the memory is usable, the block also reports whether the access sequencer's current chip-select and byte-enable levels put the memory in active or standby operation. Standby keeps the data and needs no wait to leave.

A sleep command that arrives during a wait is remembered. When the wait ends, the block returns straight to deep power down and never signals ready.

Top module: `psram_pwr_mgr`

## Requirements
- R1: While reset is asserted at a clock edge, the outputs after that edge are dpd_sel = 1, mem_ready = 0, data_lost = 0 and pwr_mode = 2'b00, and a power-up wait starts.
- R2: mem_ready stays 0 for the first WAIT_CYCLES-1 clock edges after reset is released and becomes 1 after edge number WAIT_CYCLES, unless a sleep command is pending (R7).
- R3: When mem_ready is 1 and dpd_enter is 1 at a clock edge, dpd_sel becomes 0 and mem_ready becomes 0 after that edge.
- R4: While dpd_sel is 0, it stays 0 at every edge where dpd_exit is 0, and dpd_enter has no effect.
- R5: When dpd_sel is 0 and dpd_exit is 1 at an edge, dpd_sel becomes 1 after that edge, and mem_ready becomes 1 exactly WAIT_CYCLES edges later.
- R6: data_lost becomes 1 on every edge that leaves deep power down, and it stays 1 until an edge with lost_clr = 1 and no exit from deep power down. When both happen at the same edge, the set wins.
- R7: A dpd_enter seen at any edge during a wait is held. At the edge that ends the wait, the block goes to deep power down (dpd_sel = 0) without mem_ready ever being 1.
- R8: dpd_exit has no effect outside deep power down.
- R9: pwr_mode encodes the state as 2'b00 for a wait, 2'b11 for deep power down, 2'b10 for active and 2'b01 for standby. When the memory is ready, the mode is active if mem_cs_n = 0 and at least one mem_be_n bit is 0, and standby otherwise.
- R10: The wait counter is reloaded on every entry into a wait, so each wake-up waits the full WAIT_CYCLES edges.
- R11: When dpd_enter and dpd_exit are both 1 at one edge, the block enters deep power down if it is ready and leaves it if it is asleep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dpd_enter | input | 1 | Host command to enter deep power down |
| dpd_exit | input | 1 | Host command to leave deep power down |
| lost_clr | input | 1 | Host clear of the data-lost flag |
| mem_cs_n | input | 1 | Chip-select level driven by the access sequencer |
| mem_be_n | input | BE_W | Byte-enable levels driven by the access sequencer, active low |
| dpd_sel | output | 1 | Deep-power-down select pin level, low means asleep |
| mem_ready | output | 1 | The memory may be accessed |
| data_lost | output | 1 | Sticky flag: contents were lost in deep power down |
| pwr_mode | output | 2 | Current power mode, encoded as in R9 |

## Verification
The wake timing is tried with idle command streams, which pin the exact edge at which ready rises both after reset and after each wake-up. Collisions of commands are driven on purpose. These are sleep during a wait, enter and exit together in each state, and clear together with an exit. They separate the priority rules from the plain transitions. A long seeded random stream mixes all commands with random chip-select and byte-enable levels, and every cycle is compared with a reference model. This shows up any mode misclassification and any counter that fails to reload.

// File: rtl/psm_pkg.sv
// Package psm_pkg
// Shared state type and power-mode encodings for the pseudo-SRAM power
// state manager. Assumes a two-bit mode output toward the host.
package psm_pkg;

    typedef enum logic [1:0] {
        ST_PWRUP = 2'b00,
        ST_READY = 2'b01,
        ST_DEEP  = 2'b10,
        ST_WAKE  = 2'b11
    } psm_state_e;

    localparam logic [1:0] MODE_WAIT    = 2'b00;
    localparam logic [1:0] MODE_STANDBY = 2'b01;
    localparam logic [1:0] MODE_ACTIVE  = 2'b10;
    localparam logic [1:0] MODE_DEEP    = 2'b11;

endpackage

// File: rtl/psm_wait_timer.sv
// Module psm_wait_timer
// Counts down a stabilisation wait of WAIT_CYCLES clock edges. The count
// is loaded on reset and on every load pulse, and it decrements while run
// is high. done is high in the last cycle of the wait. Assumes
// WAIT_CYCLES >= 1 and that the caller leaves the wait on done.
module psm_wait_timer #(
    parameter int unsigned WAIT_CYCLES = 20000,
    localparam int unsigned CNT_W      = $clog2(WAIT_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic done
);

    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WAIT_CYCLES);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Reload on reset or load, otherwise count down while the wait runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= LOAD_VAL;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
        end else if (run && cnt_q > ONE) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    // The wait ends when the last cycle of the count is reached.
    always_comb done = run && (cnt_q == ONE);

    // R10
    wait_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q >= ONE) && (cnt_q <= LOAD_VAL));

    // R10
    wait_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !done && !load) |=> (cnt_q == $past(cnt_q) - ONE));

endmodule

// File: rtl/psm_req_hold.sv
// Module psm_req_hold
// Remembers a sleep command that arrives while a wait is running, so the
// wait can end in deep power down. held includes a command seen in the
// current cycle. Assumes consume is high only in the last wait cycle.
module psm_req_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic in_wait,
    input  logic req,
    input  logic consume,
    output logic held
);

    logic pend_q;

    // Capture a command during a wait; drop it when the wait ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (consume) begin
            pend_q <= 1'b0;
        end else if (in_wait && req) begin
            pend_q <= 1'b1;
        end
    end

    // A command in the current wait cycle counts as held as well.
    always_comb held = pend_q || (in_wait && req);

    // R7
    pend_only_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> in_wait);

endmodule

// File: rtl/psm_mode_decode.sv
// Module psm_mode_decode
// Classifies the power mode from the sequencer state and the pin levels
// that the access sequencer drives. Assumes active-low chip select and
// byte enables; one low byte enable with a low chip select means active.
module psm_mode_decode
    import psm_pkg::*;
#(
    parameter int unsigned BE_W = 2
) (
    input  psm_state_e      state,
    input  logic            cs_n,
    input  logic [BE_W-1:0] be_n,
    output logic [1:0]      mode
);

    logic any_lane;

    // At least one byte lane is enabled.
    always_comb any_lane = ~&be_n;

    // Map the state and the pin levels to the mode encoding.
    always_comb begin
        unique case (state)
            ST_PWRUP, ST_WAKE: mode = MODE_WAIT;
            ST_DEEP:           mode = MODE_DEEP;
            default:           mode = (!cs_n && any_lane) ? MODE_ACTIVE : MODE_STANDBY;
        endcase
    end

endmodule

// File: rtl/psram_pwr_mgr.sv
// Module psram_pwr_mgr
// Sequences a pseudo-SRAM through the power-up wait, ready (active or
// standby), deep power down and wake wait. It owns the deep-power-down
// select pin and holds the access sequencer off until the memory is
// usable. Assumes host commands are synchronous to clk and one cycle
// long or longer.
module psram_pwr_mgr
    import psm_pkg::*;
#(
    parameter int unsigned WAIT_CYCLES = 20000,
    parameter int unsigned BE_W        = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dpd_enter,
    input  logic            dpd_exit,
    input  logic            lost_clr,
    input  logic            mem_cs_n,
    input  logic [BE_W-1:0] mem_be_n,
    output logic            dpd_sel,
    output logic            mem_ready,
    output logic            data_lost,
    output logic [1:0]      pwr_mode
);

    psm_state_e state_q, state_d;
    logic       lost_q;
    logic       in_wait;
    logic       wake_go;
    logic       timer_done;
    logic       sleep_held;

    // A wait is either the power-up wait or the wake wait.
    always_comb in_wait = (state_q == ST_PWRUP) || (state_q == ST_WAKE);

    // Leaving deep power down starts a fresh wait.
    always_comb wake_go = (state_q == ST_DEEP) && dpd_exit;

    psm_wait_timer #(
        .WAIT_CYCLES (WAIT_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wake_go),
        .run   (in_wait),
        .done  (timer_done)
    );

    psm_req_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_wait (in_wait),
        .req     (dpd_enter),
        .consume (timer_done),
        .held    (sleep_held)
    );

    psm_mode_decode #(
        .BE_W (BE_W)
    ) u_mode (
        .state (state_q),
        .cs_n  (mem_cs_n),
        .be_n  (mem_be_n),
        .mode  (pwr_mode)
    );

    // Next-state selection for the power sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PWRUP, ST_WAKE: begin
                if (timer_done) begin
                    state_d = sleep_held ? ST_DEEP : ST_READY;
                end
            end
            ST_READY: begin
                if (dpd_enter) begin
                    state_d = ST_DEEP;
                end
            end
            default: begin
                if (dpd_exit) begin
                    state_d = ST_WAKE;
                end
            end
        endcase
    end

    // State register, starting in the power-up wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PWRUP;
        end else begin
            state_q <= state_d;
        end
    end

    // Sticky data-lost flag; a wake-up wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lost_q <= 1'b0;
        end else if (wake_go) begin
            lost_q <= 1'b1;
        end else if (lost_clr) begin
            lost_q <= 1'b0;
        end
    end

    // Pin and flag outputs follow the registered state.
    always_comb begin
        dpd_sel   = (state_q != ST_DEEP);
        mem_ready = (state_q == ST_READY);
        data_lost = lost_q;
    end

    // R2
    ready_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ready) |-> $past(timer_done));

    // R3
    enter_from_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ready && dpd_enter) |=> (!dpd_sel && !mem_ready));

    // R4
    deep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dpd_sel && !dpd_exit) |=> !dpd_sel);

    // R5
    wake_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dpd_sel && dpd_exit) |=> (dpd_sel && !mem_ready && data_lost));

    // R6
    lost_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_lost && !lost_clr) |=> data_lost);

    // R7
    pend_skip_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_done && sleep_held) |=> (!dpd_sel && !mem_ready));

    // R9
    mode_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ready |-> (pwr_mode == MODE_ACTIVE || pwr_mode == MODE_STANDBY));

    // R9
    mode_deep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dpd_sel |-> (pwr_mode == MODE_DEEP));

endmodule

// File: tb/psram_pwr_mgr_tb.sv
module psram_pwr_mgr_tb;

    localparam int W = 37;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       dpd_enter, dpd_exit, lost_clr, mem_cs_n;
    logic [1:0] mem_be_n;
    logic       dpd_sel, mem_ready, data_lost;
    logic [1:0] pwr_mode;

    int n_vec  = 0;
    int n_fail = 0;

    // Model state: 0 wait, 1 ready, 2 deep.
    int m_st, m_cnt;
    bit m_pend, m_lost;

    always #4 clk = ~clk;

    psram_pwr_mgr #(.WAIT_CYCLES(W), .BE_W(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .dpd_enter(dpd_enter), .dpd_exit(dpd_exit),
        .lost_clr(lost_clr), .mem_cs_n(mem_cs_n), .mem_be_n(mem_be_n),
        .dpd_sel(dpd_sel), .mem_ready(mem_ready), .data_lost(data_lost),
        .pwr_mode(pwr_mode)
    );

    function automatic int exp_mode(int st, bit cs, logic [1:0] be);
        if (st == 0) return 0;
        if (st == 2) return 3;
        return (!cs && be != 2'b11) ? 2 : 1;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step(bit rst, bit e, bit x, bit c);
        if (!rst) begin
            m_st = 0; m_cnt = W; m_pend = 0; m_lost = 0;
            return;
        end
        if (m_st == 2 && x) m_lost = 1;
        else if (c) m_lost = 0;
        case (m_st)
            0: begin
                if (m_cnt == 1) begin
                    m_st = (m_pend || e) ? 2 : 1;
                    m_pend = 0;
                end else begin
                    if (e) m_pend = 1;
                    m_cnt--;
                end
            end
            1: if (e) m_st = 2;
            default: if (x) begin m_st = 0; m_cnt = W; end
        endcase
    endtask

    task automatic compare_all();
        check("R5 dpd_sel", int'(dpd_sel), (m_st != 2) ? 1 : 0);
        check("R2 mem_ready", int'(mem_ready), (m_st == 1) ? 1 : 0);
        check("R6 data_lost", int'(data_lost), int'(m_lost));
        check("R9 pwr_mode", int'(pwr_mode), exp_mode(m_st, mem_cs_n, mem_be_n));
    endtask

    // Drive inputs after a falling edge, clock once, compare after the next falling edge.
    task automatic step(bit e, bit x, bit c, bit cs, logic [1:0] be);
        dpd_enter = e; dpd_exit = x; lost_clr = c; mem_cs_n = cs; mem_be_n = be;
        @(posedge clk);
        model_step(rst_n, e, x, c);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 1, 2'b11);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 3; i++) step(1, 1, 1, 0, 2'b00);
        // R1: reset state
        check("R1 dpd_sel", int'(dpd_sel), 1);
        check("R1 mem_ready", int'(mem_ready), 0);
        check("R1 data_lost", int'(data_lost), 0);
        check("R1 pwr_mode", int'(pwr_mode), 0);
        rst_n = 1'b1;
        // R2: ready exactly W edges after release
        idle(W - 1);
        check("R2 not yet ready", int'(mem_ready), 0);
        idle(1);
        check("R2 ready at W", int'(mem_ready), 1);
        // R9: mode patterns while ready
        step(0, 0, 0, 0, 2'b00); check("R9 active both", int'(pwr_mode), 2);
        step(0, 0, 0, 0, 2'b10); check("R9 active low lane", int'(pwr_mode), 2);
        step(0, 0, 0, 0, 2'b01); check("R9 active high lane", int'(pwr_mode), 2);
        step(0, 0, 0, 0, 2'b11); check("R9 standby no lane", int'(pwr_mode), 1);
        step(0, 0, 0, 1, 2'b00); check("R9 standby cs high", int'(pwr_mode), 1);
        // R8: exit ignored when ready
        step(0, 1, 0, 1, 2'b11);
        check("R8 exit ignored", int'(mem_ready), 1);
        check("R8 lost untouched", int'(data_lost), 0);
        // R3: enter from ready
        step(1, 0, 0, 1, 2'b11);
        check("R3 pin low", int'(dpd_sel), 0);
        check("R3 pwr_mode deep", int'(pwr_mode), 3);
        // R4: hold, extra enters ignored
        for (int i = 0; i < 8; i++) step(1, 0, 1, 0, 2'b00);
        check("R4 still deep", int'(dpd_sel), 0);
        // R11: enter and exit together while asleep leaves
        step(1, 1, 0, 1, 2'b11);
        check("R11 wake wins", int'(dpd_sel), 1);
        check("R6 lost set", int'(data_lost), 1);
        // R5 R10: full wait after wake
        idle(W - 1);
        check("R10 full wait", int'(mem_ready), 0);
        idle(1);
        check("R5 ready after wake", int'(mem_ready), 1);
        // R6: clear
        step(0, 0, 1, 1, 2'b11);
        check("R6 cleared", int'(data_lost), 0);
        // R7: sleep request during wake wait
        step(1, 0, 0, 1, 2'b11);
        step(0, 1, 0, 1, 2'b11);
        idle(5);
        step(1, 0, 0, 1, 2'b11);
        for (int i = 0; i < W; i++) begin
            step(0, 0, 0, 0, 2'b00);
            check("R7 never ready", int'(mem_ready), 0);
        end
        check("R7 back asleep", int'(dpd_sel), 0);
        // R6: set wins over clear
        step(0, 1, 1, 1, 2'b11);
        check("R6 set wins", int'(data_lost), 1);
        idle(W);
        // R11: both while ready enters
        step(1, 1, 0, 1, 2'b11);
        check("R11 enter wins", int'(dpd_sel), 0);
        // Random stream
        for (int i = 0; i < 6000; i++) begin
            step(($urandom % 24) == 0, ($urandom % 10) == 0, ($urandom % 16) == 0,
                 ($urandom % 3) == 0, 2'($urandom));
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule